// File: doc/BRIEF.md
# Blocked Prefix Scan Engine

This engine takes a vector of N unsigned W-bit words in a single load and returns the inclusive prefix vector. Output element i is s0 ⊕ s1 ⊕ … ⊕ si. The operator ⊕ is picked at load time from a small set of associative operators. Two of those operators are not commutative. Every combine places the element that comes earlier in the sequence as its left operand, so both kinds of operator give correct results.

The work is split into three phases over B = N/L blocks, where L = log2(N) and each block holds L consecutive words.
- **Local phase:** every block runs its own sequential running scan. All blocks step in parallel.
- **Tail phase:** a logarithmic-step scan runs over the last word of each block. Each of those words becomes the running total up to that point.
- **Carry phase:** in every block after the first, each word except the last combines with the tail of the block before it, in a single cycle.

A one-cycle pulse on `start` begins a scan. `done` pulses once when the prefix vector on `result` is final. That vector stays on `result` until the next accepted start. N must be a power of two, at least 4, and N/log2(N) must be a whole number (4, 16, 256 and so on).

Top module: `blocked_scan_unit`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `busy` and `done` are 0 and `result` is all zeros.
- R2: A `start` sampled while `busy` is 0 is accepted. That clock edge captures `operands` and `op_sel`, and `busy` is 1 from the next cycle onward. A start made in the same cycle that `done` is high is also accepted.
- R3: `done` is high for exactly one cycle. It is first seen log2(N) + ceil(log2(N/log2(N))) clock edges after the accepting edge, which is 6 edges for N = 16. `busy` falls in that same cycle.
- R4: When `done` is high, bits [i*W +: W] of `result` hold the inclusive prefix of the captured words 0..i. Word i of `operands` occupies the same bit positions.
- R5: `op_sel` codes 0 to 5 select, in order: addition modulo 2^W, unsigned maximum, unsigned minimum, bitwise AND, bitwise OR and bitwise XOR.
- R6: Code 6 selects the keep-left operator (a ⊕ b = a), so every result word equals word 0. Code 7 selects the keep-right operator (a ⊕ b = b), so every result word equals its own input word. This shows that the earlier element is always the left operand.
- R7: A `start` made while `busy` is 1 is ignored. The running scan keeps its captured data and operator, and its `done` timing does not change.
- R8: Changes on `op_sel` or `operands` after the accepting edge have no effect. While idle and without a start, `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Starts a scan when idle |
| op_sel | input | 3 | Operator code, see R5 and R6 |
| operands | input | N*W | Input words, word i at bits [i*W +: W] |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse when `result` is final |
| result | output | N*W | Prefix vector, word i at bits [i*W +: W] |

## Verification
An incrementing ramp under addition shows whether carries cross block boundaries with the right totals. Words of all ones show that addition wraps modulo 2^W. Alternating high and low words, and descending words, separate maximum from minimum and expose any tail that is missed in the logarithmic rounds. Random words under the keep-left and keep-right operators reveal any swap of operand order in any of the three phases. Mid-scan start pulses, toggling of inputs while busy, and back-to-back starts on the `done` cycle check the sequencing.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
// Shared types for the blocked prefix scan engine.
// Assumes nothing beyond SystemVerilog package support.
package bscan_pkg;

    // Operator codes; values are visible at the op_sel port.
    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_MAX   = 3'd1,
        OP_MIN   = 3'd2,
        OP_AND   = 3'd3,
        OP_OR    = 3'd4,
        OP_XOR   = 3'd5,
        OP_LEFT  = 3'd6,
        OP_RIGHT = 3'd7
    } scan_op_e;

    // Sequencer phases.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOCAL = 2'd1,
        PH_TAILS = 2'd2,
        PH_CARRY = 2'd3
    } scan_phase_e;

endpackage

// File: rtl/bscan_op.sv
`timescale 1ns/1ps
// Combinational combine unit: y = lhs (op) rhs.
// Assumes lhs is the earlier element of the sequence; all operators are
// associative, keep-left and keep-right are deliberately non-commutative.
module bscan_op
    import bscan_pkg::*;
#(
    parameter int W = 8
) (
    input  scan_op_e       op,
    input  logic [W-1:0]   lhs,
    input  logic [W-1:0]   rhs,
    output logic [W-1:0]   y
);

    // Apply the selected operator with lhs on the left.
    always_comb begin
        case (op)
            OP_ADD:   y = lhs + rhs;
            OP_MAX:   y = (lhs > rhs) ? lhs : rhs;
            OP_MIN:   y = (lhs < rhs) ? lhs : rhs;
            OP_AND:   y = lhs & rhs;
            OP_OR:    y = lhs | rhs;
            OP_XOR:   y = lhs ^ rhs;
            OP_LEFT:  y = lhs;
            OP_RIGHT: y = rhs;
            default:  y = lhs + rhs;
        endcase
    end

endmodule

// File: rtl/bscan_ctrl.sv
`timescale 1ns/1ps
// Phase sequencer: idle -> local scan (L-1 steps) -> tail rounds (LOGB steps)
// -> carry (1 step) -> idle with a one-cycle done pulse.
// Assumes L >= 2 and LOGB >= 1 (N >= 4); step is wide enough for L-1.
module bscan_ctrl
    import bscan_pkg::*;
#(
    parameter int L    = 4,
    parameter int LOGB = 2,
    parameter int CW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           load,
    output scan_phase_e    phase,
    output logic [CW-1:0]  step,
    output logic           busy,
    output logic           done
);

    localparam logic [CW-1:0] LOCAL_LAST = CW'(L - 1);
    localparam logic [CW-1:0] TAILS_LAST = CW'(LOGB - 1);

    assign busy = (phase != PH_IDLE);
    assign load = start && (phase == PH_IDLE);

    // Advance phase and step counter, raise done after the carry step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_LOCAL;
                        step  <= CW'(1);
                    end
                end
                PH_LOCAL: begin
                    if (step == LOCAL_LAST) begin
                        phase <= PH_TAILS;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                PH_TAILS: begin
                    if (step == TAILS_LAST) begin
                        phase <= PH_CARRY;
                        step  <= '0;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    step  <= '0;
                    done  <= 1'b1;
                end
            endcase
        end
    end

    // R3: done lasts one cycle and only follows the carry step.
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_done_after_carry: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == PH_CARRY));
    // R7: a start while busy does not cut a scan short.
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && phase != PH_CARRY) |=> busy);
    // R3: local step index stays in its range.
    a_r3_local_step_range: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOCAL) |-> (step >= CW'(1) && step <= LOCAL_LAST));

endmodule

// File: rtl/blocked_scan_unit.sv
`timescale 1ns/1ps
// Blocked three-phase inclusive prefix scan over N words of W bits.
// Assumes N is a power of two, N >= 4, and N / log2(N) is an integer.
// Each word owns one register and one combine unit; the sequencer picks
// which left operand, if any, each word combines with in a given cycle.
module blocked_scan_unit
    import bscan_pkg::*;
#(
    parameter int N = 16,
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op_sel,
    input  logic [N*W-1:0] operands,
    output logic           busy,
    output logic           done,
    output logic [N*W-1:0] result
);

    localparam int L    = $clog2(N);
    localparam int B    = N / L;
    localparam int LOGB = (B > 1) ? $clog2(B) : 1;
    localparam int CW   = $clog2(L) + 1;

    scan_phase_e     phase;
    logic [CW-1:0]   step;
    logic            load;
    scan_op_e        op_q;
    logic [N*W-1:0]  cur;

    bscan_ctrl #(.L(L), .LOGB(LOGB), .CW(CW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .phase (phase),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    // Capture the operator with the operands on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)    op_q <= OP_ADD;
        else if (load) op_q <= scan_op_e'(op_sel);
    end

    for (genvar i = 0; i < N; i++) begin : g_word
        localparam int BLK     = i / L;
        localparam int OFF     = i % L;
        localparam int PREV    = (OFF != 0) ? i - 1 : i;
        localparam int CARRY_S = (BLK >= 1) ? BLK * L - 1 : i;

        logic [W-1:0]    val_q;
        logic [W-1:0]    lhs;
        logic [W-1:0]    y;
        logic            upd;
        logic [W-1:0]    cand [LOGB];
        logic [LOGB-1:0] tail_ok;

        // Tail-round sources: tail of the block 2^r blocks earlier.
        for (genvar r = 0; r < LOGB; r++) begin : g_round
            localparam int DIST = (1 << r) * L;
            localparam int SRC  = (i >= DIST) ? i - DIST : i;
            assign cand[r]    = cur[SRC*W +: W];
            assign tail_ok[r] = (BLK >= (1 << r));
        end

        // Choose this word's left operand for the current phase and step.
        always_comb begin
            upd = 1'b0;
            lhs = cur[PREV*W +: W];
            case (phase)
                PH_LOCAL: begin
                    if (OFF != 0 && step == CW'(OFF)) upd = 1'b1;
                end
                PH_TAILS: begin
                    if (OFF == L - 1) begin
                        for (int r = 0; r < LOGB; r++) begin
                            if (step == CW'(r) && tail_ok[r]) begin
                                upd = 1'b1;
                                lhs = cand[r];
                            end
                        end
                    end
                end
                PH_CARRY: begin
                    lhs = cur[CARRY_S*W +: W];
                    if (BLK >= 1 && OFF != L - 1) upd = 1'b1;
                end
                default: upd = 1'b0;
            endcase
        end

        bscan_op #(.W(W)) u_op (
            .op  (op_q),
            .lhs (lhs),
            .rhs (val_q),
            .y   (y)
        );

        // Load the input word or store the combined value.
        always_ff @(posedge clk) begin
            if (!rst_n)     val_q <= '0;
            else if (load)  val_q <= operands[i*W +: W];
            else if (upd)   val_q <= y;
        end

        assign cur[i*W +: W] = val_q;
    end

    assign result = cur;

    // R2: an accepted start makes the unit busy next cycle.
    a_r2_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);
    // R8: idle without start keeps the result.
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(result));
    // R8: the captured operator does not move during a scan.
    a_r8_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q));
    // R4: word 0 is its own prefix and never changes during a scan.
    a_r4_first_word_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(result[W-1:0]));

endmodule

// File: tb/blocked_scan_unit_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference (per-cycle busy/done, prefix by loop),
// compared after every clock edge.
module blocked_scan_unit_bench;

    localparam int N    = 16;
    localparam int W    = 8;
    localparam int L    = $clog2(N);
    localparam int B    = N / L;
    localparam int LOGB = $clog2(B);
    localparam int LAT  = L + LOGB;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2:0]     op_sel = '0;
    logic [N*W-1:0] operands = '0;
    logic           busy;
    logic           done;
    logic [N*W-1:0] result;

    int             checks = 0;
    int             fails = 0;
    int             cyc = 0;
    bit             ref_busy = 0;
    bit             ref_done = 0;
    int             ref_left = 0;
    logic [N*W-1:0] ref_res = '0;
    logic [N*W-1:0] ref_pend = '0;

    blocked_scan_unit #(.N(N), .W(W)) u_blocked_scan_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel),
        .operands(operands), .busy(busy), .done(done), .result(result)
    );

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] comb(int op, logic [W-1:0] a, logic [W-1:0] b);
        case (op)
            0: return a + b;
            1: return (a > b) ? a : b;
            2: return (a < b) ? a : b;
            3: return a & b;
            4: return a | b;
            5: return a ^ b;
            6: return a;
            default: return b;
        endcase
    endfunction

    function automatic logic [N*W-1:0] scan(int op, logic [N*W-1:0] d);
        logic [N*W-1:0] r;
        logic [W-1:0]   acc;
        acc = d[W-1:0];
        r[W-1:0] = acc;
        for (int i = 1; i < N; i++) begin
            acc = comb(op, acc, d[i*W +: W]);
            r[i*W +: W] = acc;
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, string what,
                         logic [N*W-1:0] act, logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick(bit st, int op, logic [N*W-1:0] d, string tag);
        bit was_busy;
        start    = st;
        op_sel   = op[2:0];
        operands = d;
        @(posedge clk);
        if (rst_n) begin
            was_busy = ref_busy;
            ref_done = 0;
            if (was_busy) begin
                ref_left--;
                if (ref_left == 0) begin
                    ref_busy = 0;
                    ref_done = 1;
                    ref_res  = ref_pend;
                end
            end
            if (!was_busy && st) begin
                ref_busy = 1;
                ref_left = LAT;
                ref_pend = scan(op, d);
            end
        end
        @(negedge clk);
        check(busy == ref_busy, tag, "busy", {{(N*W-1){1'b0}}, busy}, {{(N*W-1){1'b0}}, ref_busy});
        check(done == ref_done, tag, "done", {{(N*W-1){1'b0}}, done}, {{(N*W-1){1'b0}}, ref_done});
        if (!ref_busy)
            check(result == ref_res, tag, "result", result, ref_res);
        start = 0;
    endtask

    // One scan: start, then LAT cycles with disturbed inputs (R8).
    task automatic run_scan(int op, logic [N*W-1:0] d, string tag);
        tick(1, op, d, tag);
        for (int c = 0; c < LAT; c++) tick(0, (op + 3) % 8, ~d, "R8");
    endtask

    function automatic logic [N*W-1:0] rnd_vec();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
        return v;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] ramp, ones, alt, desc;
        for (int i = 0; i < N; i++) begin
            ramp[i*W +: W] = W'(i + 1);
            ones[i*W +: W] = '1;
            alt[i*W +: W]  = (i % 2 == 0) ? W'(i * 3) : W'(255 - i * 5);
            desc[i*W +: W] = W'(200 - i * 7);
        end
        // R1: reset state, held and after release.
        for (int c = 0; c < 3; c++) tick(1, 0, ramp, "R1");
        rst_n = 1'b1;
        tick(0, 0, ramp, "R1");
        // R4/R5: each basic operator on several patterns, back-to-back (R2).
        for (int op = 0; op < 6; op++) begin
            run_scan(op, ramp, "R5");
            run_scan(op, alt, "R5");
            run_scan(op, desc, "R4");
            run_scan(op, rnd_vec(), "R4");
        end
        run_scan(0, ones, "R5");
        // R6: non-commutative operators expose operand order.
        for (int k = 0; k < 3; k++) begin
            run_scan(6, rnd_vec(), "R6");
            run_scan(7, rnd_vec(), "R6");
        end
        // R7: start pulses during a scan are ignored.
        tick(1, 0, ramp, "R7");
        tick(0, 0, ramp, "R7");
        tick(1, 6, alt, "R7");
        for (int c = 0; c < LAT - 2; c++) tick(1, 1, desc, "R7");
        // R8: idle hold with changing inputs and no start.
        for (int c = 0; c < 4; c++) tick(0, c, rnd_vec(), "R8");
        // R2: start on the very cycle done is seen.
        run_scan(2, alt, "R2");
        run_scan(3, rnd_vec(), "R2");
        tick(0, 0, '0, "R3");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule